// File: doc/BRIEF.md
# Per-Switch Pulse-by-Pulse Trip and Warning Guard

This block sits between the synchronized gate commands of a three-phase inverter bridge and the gate drivers. For each of the six inverter switches it receives an active-low command, a short-circuit comparator flag and a current-limit comparator flag. It produces a gate enable for each switch, a shared active-low fault output and a shared active-low warning output.

A short-circuit flag that arrives while a switch is commanded on removes the gate of that switch only. The gate stays off for the rest of that command pulse and the fault output goes low. A current-limit flag that arrives during a command pulse pulls the warning output low and leaves the gate alone. Each switch re-arms by itself on its next activating command edge, which is a high-to-low transition of its command. The shared outputs release once no switch holds a latched condition. The braking switch is driven elsewhere and does not pass through this guard. Analog sensing and the trip thresholds are handled upstream of the comparator flags.

Top module: `pbp_trip_guard`

## Requirements
- R1: While `rst_n` is low at a clock edge, `gate` becomes all zeros after that edge and `fault_n` and `warn_n` become 1. Out of reset, every command is treated as having been inactive (high).
- R2: If no trip is latched for switch i, `gate[i]` in the cycle after an edge equals the inverse of `cmd_n[i]` sampled at that edge (0 = commanded on).
- R3: If `sc_flag[i]` is 1 while `cmd_n[i]` is 0 at an edge, then after that edge `gate[i]` is 0 and `fault_n` is 0. The gates of the other switches are unaffected.
- R4: After a trip, `gate[i]` stays 0 for the rest of the current command pulse, even once `sc_flag[i]` returns to 0.
- R5: `sc_flag[i]` and `cl_flag[i]` are ignored at any edge where `cmd_n[i]` is 1, and `fault_n` and `warn_n` do not change because of them.
- R6: A latched trip on switch i stays latched, with `fault_n` low, until an edge where `cmd_n[i]` is 0 and was 1 at the previous edge. After that edge the trip of switch i is released and `gate[i]` follows R2. An activating edge on another switch does not release it.
- R7: If `cl_flag[i]` is 1 while `cmd_n[i]` is 0 at an edge, then after that edge `warn_n` is 0 and `gate[i]` is unchanged.
- R8: A latched warning on switch i is released only by the next activating (high-to-low) edge of `cmd_n[i]`.
- R9: `fault_n` is 0 exactly when at least one switch holds a latched trip. `warn_n` is 0 exactly when at least one switch holds a latched warning.
- R10: If a flag is present at the same edge as the activating command edge of its switch, the flag wins. The condition is latched for the new pulse, and for a trip `gate[i]` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_n | input | 6 | Synchronized gate commands, active low, one per switch |
| sc_flag | input | 6 | Short-circuit comparator flags, active high |
| cl_flag | input | 6 | Current-limit comparator flags, active high |
| gate | output | 6 | Gate enables to the drivers, active high |
| fault_n | output | 1 | Shared short-circuit fault, active low |
| warn_n | output | 1 | Shared current-limit warning, active low |

## Verification
Every result is due exactly one clock edge after its stimulus. This applies to a gate following its command, a trip removing a gate, a fault or warning going low, and a release on an activating edge. No result is registered twice.

The bench changes inputs on the falling clock edge and checks all three outputs on the following falling edge. That edge comes after the single rising edge that captures the stimulus.

The expected values come from a per-switch latch model written from the requirements. The bench runs directed sequences on each of the six switches in turn, then a long pseudo-random sweep, and compares the model with the outputs every cycle.

// File: rtl/pbp_pkg.sv
// Shared constants and types for the pulse-by-pulse trip guard.
// Assumes one guard slice per inverter switch.
package pbp_pkg;
    localparam int unsigned PBP_SWITCHES = 6;

    // Latched per-switch protection state.
    typedef struct packed {
        logic trip;   // short-circuit trip held for the current pulse
        logic warn;   // current-limit warning held for the current pulse
    } pbp_latch_t;
endpackage

// File: rtl/pbp_edge_detect.sv
// Detects the activating (high-to-low) edge of each active-low command.
// Assumes the commands are already synchronized to clk. After reset the
// previous value is taken as inactive, so a command that is already low
// when reset is released counts as a new pulse.
module pbp_edge_detect #(
    parameter int unsigned WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] cmd_n,
    output logic [WIDTH-1:0] start
);
    logic [WIDTH-1:0] prev_n;

    // Hold the command from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_n <= '1;
        else        prev_n <= cmd_n;
    end

    // Activating edge: inactive before, active now.
    assign start = prev_n & ~cmd_n;
endmodule

// File: rtl/pbp_switch_guard.sv
// Protection slice for a single switch. It latches a short-circuit trip
// and a current-limit warning that occur during a command pulse. Both are
// released on the next activating command edge; a flag on that same edge
// wins. The gate is the command masked by the trip, all registered, so
// each result appears one edge after its cause. Flags seen while the
// command is inactive are ignored.
module pbp_switch_guard
    import pbp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_on,
    input  logic       start,
    input  logic       sc_hit,
    input  logic       cl_hit,
    output logic       gate_en,
    output pbp_latch_t state
);
    pbp_latch_t state_q;
    pbp_latch_t state_d;
    logic       gate_q;

    // Next latch state: set while the switch is on, release on a new pulse.
    always_comb begin
        state_d.trip = (cmd_on & sc_hit) | (state_q.trip & ~start);
        state_d.warn = (cmd_on & cl_hit) | (state_q.warn & ~start);
    end

    // Register the latches and the masked gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
            gate_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            gate_q  <= cmd_on & ~state_d.trip;
        end
    end

    assign gate_en = gate_q;
    assign state   = state_q;
endmodule

// File: rtl/pbp_flag_merge.sv
// Combines the per-switch latches into the shared active-low fault and
// warning outputs. Assumes the inputs come straight from registers.
module pbp_flag_merge
    import pbp_pkg::*;
#(
    parameter int unsigned WIDTH = 6
) (
    input  pbp_latch_t [WIDTH-1:0] latches,
    output logic                   fault_n,
    output logic                   warn_n
);
    logic [WIDTH-1:0] trip_vec;
    logic [WIDTH-1:0] warn_vec;

    // Split the struct array into flat vectors.
    always_comb begin
        for (int k = 0; k < WIDTH; k++) begin
            trip_vec[k] = latches[k].trip;
            warn_vec[k] = latches[k].warn;
        end
    end

    assign fault_n = ~(|trip_vec);
    assign warn_n  = ~(|warn_vec);
endmodule

// File: rtl/pbp_trip_guard.sv
// Top level of the per-switch pulse-by-pulse trip and warning guard.
// It places one edge detector across all commands, one guard slice per
// switch, and one merge stage for the shared open-drain-style outputs.
// Assumes all inputs are synchronous to clk.
module pbp_trip_guard
    import pbp_pkg::*;
#(
    parameter int unsigned N_SW = PBP_SWITCHES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_SW-1:0] cmd_n,
    input  logic [N_SW-1:0] sc_flag,
    input  logic [N_SW-1:0] cl_flag,
    output logic [N_SW-1:0] gate,
    output logic            fault_n,
    output logic            warn_n
);
    logic       [N_SW-1:0] start;
    pbp_latch_t [N_SW-1:0] latches;

    pbp_edge_detect #(.WIDTH(N_SW)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd_n (cmd_n),
        .start (start)
    );

    for (genvar g = 0; g < N_SW; g++) begin : g_sw
        pbp_switch_guard u_guard (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd_on  (~cmd_n[g]),
            .start   (start[g]),
            .sc_hit  (sc_flag[g]),
            .cl_hit  (cl_flag[g]),
            .gate_en (gate[g]),
            .state   (latches[g])
        );
    end

    pbp_flag_merge #(.WIDTH(N_SW)) u_merge (
        .latches (latches),
        .fault_n (fault_n),
        .warn_n  (warn_n)
    );
endmodule

// File: rtl/pbp_trip_guard_checker.sv
// Port-level temporal checks for pbp_trip_guard. It is attached to the
// top module by the bind statement at the end of this file.
module pbp_trip_guard_checker #(
    parameter int unsigned N_SW = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_SW-1:0] cmd_n,
    input logic [N_SW-1:0] sc_flag,
    input logic [N_SW-1:0] cl_flag,
    input logic [N_SW-1:0] gate,
    input logic            fault_n,
    input logic            warn_n
);
    // R2: a gate is on only if its command was active at the previous edge.
    p_gate_needs_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gate & $past(cmd_n)) == '0);

    // R3: a trip during an active command removes that gate.
    p_trip_blanks_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate & $past(sc_flag & ~cmd_n)) == '0);

    // R3: a trip during an active command drives the fault low.
    p_trip_sets_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((sc_flag & ~cmd_n) != '0) |=> !fault_n);

    // R7: a current-limit hit during an active command drives the warning low.
    p_limit_sets_warn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cl_flag & ~cmd_n) != '0) |=> !warn_n);

    // R6: the fault persists while no activating edge arrives.
    p_fault_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n && (($past(cmd_n) & ~cmd_n) == '0)) |=> !fault_n);

    // R8: the warning persists while no activating edge arrives.
    p_warn_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!warn_n && (($past(cmd_n) & ~cmd_n) == '0)) |=> !warn_n);
endmodule

bind pbp_trip_guard pbp_trip_guard_checker #(.N_SW(N_SW)) u_pbp_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_n   (cmd_n),
    .sc_flag (sc_flag),
    .cl_flag (cl_flag),
    .gate    (gate),
    .fault_n (fault_n),
    .warn_n  (warn_n)
);

// File: tb/pbp_trip_guard_bench.sv
// Self-checking bench: directed sequences on every switch, then an LFSR sweep.
module pbp_trip_guard_bench;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] cmd_n = '1;
    logic [N-1:0] sc_flag = '0;
    logic [N-1:0] cl_flag = '0;
    logic [N-1:0] gate;
    logic         fault_n;
    logic         warn_n;

    int tests = 0;
    int fails = 0;

    // Requirement model state.
    logic [N-1:0] m_prev = '1;
    logic [N-1:0] m_trip = '0;
    logic [N-1:0] m_warn = '0;
    logic [N-1:0] m_gate = '0;

    always #10 clk = ~clk;

    pbp_trip_guard #(.N_SW(N)) u_pbp_trip_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_n   (cmd_n),
        .sc_flag (sc_flag),
        .cl_flag (cl_flag),
        .gate    (gate),
        .fault_n (fault_n),
        .warn_n  (warn_n)
    );

    task automatic check_all(input string tg, input string tf, input string tw);
        tests++;
        if (gate !== m_gate) begin
            fails++;
            $display("FAIL %s gate actual=%b expected=%b", tg, gate, m_gate);
        end
        tests++;
        if (fault_n !== ~(|m_trip)) begin
            fails++;
            $display("FAIL %s fault_n actual=%b expected=%b", tf, fault_n, ~(|m_trip));
        end
        tests++;
        if (warn_n !== ~(|m_warn)) begin
            fails++;
            $display("FAIL %s warn_n actual=%b expected=%b", tw, warn_n, ~(|m_warn));
        end
    endtask

    // Drive one cycle at the falling edge, update the model, check at the next falling edge.
    task automatic cyc(input logic [N-1:0] c, input logic [N-1:0] s, input logic [N-1:0] l,
                       input string tg, input string tf, input string tw);
        logic [N-1:0] act;
        logic [N-1:0] st;
        cmd_n   = c;
        sc_flag = s;
        cl_flag = l;
        act = ~c;
        st  = m_prev & ~c;
        m_trip = (act & s) | (m_trip & ~st);
        m_warn = (act & l) | (m_warn & ~st);
        m_gate = act & ~m_trip;
        m_prev = c;
        @(negedge clk);
        check_all(tg, tf, tw);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check_all("R1", "R1", "R1");
        rst_n = 1'b1;

        for (int i = 0; i < N; i++) begin
            logic [N-1:0] on;
            on = ~(N'(1) << i);
            cyc(on, '0, '0, "R2", "R9", "R9");                       // R2 follow command
            cyc(on, ~on, '0, "R3", "R3", "R9");                      // R3 trip
            cyc(on, '0, '0, "R4", "R3", "R9");                       // R4 stays off
            cyc('1, '0, '0, "R2", "R6", "R9");                       // R6 holds between pulses
            cyc('1, ~on, '0, "R5", "R6", "R9");                      // R5 flag while inactive
            cyc(on, '0, '0, "R6", "R6", "R9");                       // R6 release on new pulse
            cyc('1, ~on, ~on, "R5", "R5", "R5");                     // R5 both flags ignored
            cyc(on, '0, ~on, "R7", "R9", "R7");                      // R7 warning, gate kept
            cyc(on, '0, '0, "R7", "R9", "R8");
            cyc('1, '0, '0, "R2", "R9", "R8");                       // R8 held
            cyc(on, '0, '0, "R2", "R9", "R8");                       // R8 released
            cyc(on, ~on, '0, "R3", "R3", "R9");                      // R6 other-switch edge
            cyc(on & ~(N'(1) << ((i + 1) % N)), '0, '0, "R6", "R6", "R9");
            cyc('1, '0, '0, "R2", "R6", "R9");
            cyc(on, ~on, ~on, "R10", "R10", "R10");                  // R10 flag on edge wins
            cyc(on, '0, '0, "R10", "R10", "R10");
            cyc('1, '0, '0, "R2", "R9", "R9");
        end

        // R9: two trips, release one at a time
        cyc(6'b111100, 6'b000011, '0, "R3", "R9", "R9");
        cyc('1, '0, '0, "R2", "R9", "R9");
        cyc(6'b111110, '0, '0, "R6", "R9", "R9");
        cyc(6'b111111, '0, '0, "R2", "R9", "R9");
        cyc(6'b111101, '0, '0, "R6", "R9", "R9");

        // Pseudo-random sweep against the model.
        lfsr = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            logic [N-1:0] c;
            logic [N-1:0] s;
            logic [N-1:0] l;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            c = lfsr[5:0] | lfsr[11:6];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            s = lfsr[5:0] & lfsr[11:6] & {N{lfsr[15]}};
            l = lfsr[11:6] & lfsr[15:10] & {N{lfsr[14]}};
            cyc(c, s, l, "R2", "R9", "R7");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule